// File: doc/BRIEF.md
# Command-Pointer I2C Register Slave

This block is the serial front end of a small register file. It watches the two I2C lines, decodes a 7-bit device address, and turns each bus transaction into single-cycle read and write strobes on a plain register port. The register port has a 3-bit index, write data, a write strobe, read data and a read strobe. The upper four address bits are fixed at `0100`. The lower three come from strap inputs, so eight copies can share one bus.

The byte that follows an address with the direction bit at 0 is a command byte. Its low three bits load an internal register pointer. Any further bytes in that write go to the register the pointer selects. Each bus read returns the register the pointer selects. To read a chosen register, the master writes the address and the command byte, then issues a repeated START with the direction bit at 1. After every data byte moves, the pointer flips its lowest bit, so long transfers alternate between the two registers of a pair.

SCL and SDA pass through a two-flop synchronizer. The system clock must be at least 16 times the SCL rate. The bus runs at up to 100 kHz. The block drives SDA only through a pull-low enable, and it never holds SCL low.

Top module: `cmdptr_i2c_slave`

## Requirements
- R1: After a synchronous reset, `sda_pull_o`, `reg_we_o` and `reg_rd_o` are all 0 and stay 0 while the bus is idle.
- R2: An address byte whose upper seven bits equal `{4'b0100, strap_i}` is acknowledged: SDA is pulled low for the ninth clock. Any other address gets no acknowledge, and the block gives no acknowledge and no strobe until the next START.
- R3: The first byte after a matching address with direction bit 0 is acknowledged. Its bits [2:0] load the pointer, and bits [7:3] are ignored.
- R4: Each later byte in a write gives exactly one `reg_we_o` pulse with `reg_idx_o` equal to the pointer and `reg_wdata_o` equal to the byte. The byte is acknowledged, and then pointer bit 0 is inverted.
- R5: After a matching address with direction bit 1, the block sends the register the pointer selects, MSB first. It gives one `reg_rd_o` pulse, with `reg_idx_o` equal to the pointer, before each byte. It inverts pointer bit 0 after each byte. A master ACK (SDA 0 in the ninth clock) starts the next byte. A master NACK releases SDA until the next START.
- R6: `sda_pull_o` only becomes active while the synchronized SCL is low.
- R7: A START, whether first or repeated, or a STOP, detected on the synchronized lines while SCL is high, abandons any partial byte. A START begins a new address byte at once.
- R8: The pointer keeps its value across STOP and START, and a later read with no command byte continues from it.
- R9: `reg_we_o` and `reg_rd_o` are single-cycle pulses, and `sda_pull_o` is already active in the cycle in which `reg_we_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap_i | input | 3 | Strapped low bits of the device address |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_idx_o | output | 3 | Register index for the current strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_we_o` |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe; `reg_rdata_i` is taken at the end of that cycle |
| reg_rdata_i | input | 8 | Read data for `reg_idx_o` |

## Verification
Two functions can fall in the same cycle: a START that clears the bit counter, and a byte whose partial count the FSM is still advancing. The bench provokes this by sending four address bits and then a repeated START. It then checks that the next full transaction is acknowledged and writes exactly the expected registers. A second coincidence is the write strobe and the acknowledge pull, which both occur on the same edge. On every clock the bench checks that each strobe matches the next entry in its reference queue of expected index and data, and that the pull is already active whenever a write strobe appears.

// File: rtl/cmdptr_pkg.sv
package cmdptr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_RD_WAIT
    } slv_state_t;

    // Events derived from the synchronized bus lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] rx,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [ADDR_W-1:0] strap_ext);
        return rx == (base | strap_ext);
    endfunction

endpackage

// File: rtl/cmdptr_sync.sv
module cmdptr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cmdptr_cond_det.sv
module cmdptr_cond_det
    import cmdptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/cmdptr_i2c_slave.sv
module cmdptr_i2c_slave
    import cmdptr_pkg::*;
#(
    parameter int                STRAP_W   = 3,
    parameter int                IDX_W     = 3,
    parameter int                SYNC_DEPTH = 2,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic [IDX_W-1:0]   reg_idx_o,
    output logic [BYTE_W-1:0]  reg_wdata_o,
    output logic               reg_we_o,
    output logic               reg_rd_o,
    input  logic [BYTE_W-1:0]  reg_rdata_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int NLINE = 2;

    // line 0 = SCL, line 1 = SDA
    logic [NLINE-1:0] line_raw, line_s;
    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_sync
        cmdptr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (line_raw[g]),
            .dout(line_s[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    bus_evt_t evt;
    cmdptr_cond_det u_det (
        .clk  (clk),
        .rst  (rst),
        .scl_s(scl_s),
        .sda_s(sda_s),
        .evt  (evt)
    );

    slv_state_t        st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg, txreg;
    logic [IDX_W-1:0]  ptr;
    logic              rw;
    logic              hit;

    assign hit = addr_hit(shreg[BYTE_W-1:1], ADDR_BASE, ADDR_W'(strap_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            rw          <= 1'b0;
            sda_pull_o  <= 1'b0;
            reg_idx_o   <= '0;
            reg_wdata_o <= '0;
            reg_we_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
        end else begin
            reg_we_o <= 1'b0;
            reg_rd_o <= 1'b0;
            if (evt.start) begin
                st         <= ST_ADDR;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else if (evt.stop) begin
                st         <= ST_IDLE;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_CMD, ST_WR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR) begin
                                if (hit) begin
                                    sda_pull_o <= 1'b1;
                                    rw         <= shreg[0];
                                    st         <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_CMD) begin
                                ptr        <= shreg[IDX_W-1:0];
                                sda_pull_o <= 1'b1;
                                st         <= ST_CMD_ACK;
                            end else begin
                                reg_we_o    <= 1'b1;
                                reg_idx_o   <= ptr;
                                reg_wdata_o <= shreg;
                                ptr         <= ptr ^ IDX_W'(1);
                                sda_pull_o  <= 1'b1;
                                st          <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            if (rw) begin
                                reg_rd_o  <= 1'b1;
                                reg_idx_o <= ptr;
                                st        <= ST_RD_LOAD;
                            end else begin
                                st <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            st         <= ST_WR;
                        end
                    end
                    ST_RD_LOAD: begin
                        txreg      <= reg_rdata_i;
                        sda_pull_o <= ~reg_rdata_i[BYTE_W-1];
                        bitcnt     <= '0;
                        st         <= ST_RD_BIT;
                    end
                    ST_RD_BIT: begin
                        if (evt.scl_fall) begin
                            if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                                sda_pull_o <= 1'b0;
                                bitcnt     <= '0;
                                st         <= ST_RD_ACK;
                            end else begin
                                txreg      <= txreg << 1;
                                sda_pull_o <= ~txreg[BYTE_W-2];
                                bitcnt     <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            ptr <= ptr ^ IDX_W'(1);
                            st  <= evt.sda ? ST_IDLE : ST_RD_WAIT;
                        end
                    end
                    ST_RD_WAIT: begin
                        if (evt.scl_fall) begin
                            reg_rd_o  <= 1'b1;
                            reg_idx_o <= ptr;
                            st        <= ST_RD_LOAD;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmdptr_i2c_slave_chk.sv
module cmdptr_i2c_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_det,
    input logic sda_pull,
    input logic reg_we,
    input logic reg_rd
);
    // R6: the pull is only switched on while SCL is low
    assert_pull_rise_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);

    // R7: a START releases the data line on the next cycle
    assert_start_releases_R7: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_pull);

    // R9: a write strobe lasts one cycle
    assert_we_single_R9: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R9: the acknowledge pull coincides with the write strobe
    assert_we_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> sda_pull);

    // R5: a read strobe lasts one cycle
    assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);
endmodule

bind cmdptr_i2c_slave cmdptr_i2c_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .start_det(evt.start),
    .sda_pull (sda_pull_o),
    .reg_we   (reg_we_o),
    .reg_rd   (reg_rd_o)
);

// File: tb/cmdptr_i2c_slave_test.sv
module cmdptr_i2c_slave_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       pull, we, rd;
    logic [2:0] idx;
    logic [7:0] wdata, rdata;
    wire        sda_bus = m_sda & ~pull;

    cmdptr_i2c_slave uut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
        .sda_pull_o(pull), .reg_idx_o(idx), .reg_wdata_o(wdata),
        .reg_we_o(we), .reg_rd_o(rd), .reg_rdata_i(rdata)
    );

    // environment register file
    logic [7:0] rf [8];
    always @(posedge clk) if (we) rf[idx] <= wdata;
    assign rdata = rf[idx];

    // reference model state
    logic [7:0]  model [8];
    logic [2:0]  m_ptr = 3'd0;
    logic [10:0] exp_wr [$];
    logic [2:0]  exp_rd [$];
    int n_cmp = 0, n_bad = 0;
    logic pull_q = 1'b0;
    logic [10:0] e_wr;
    logic [2:0]  e_rd;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference queues
    always @(negedge clk) begin
        if (!rst) begin
            if (we) begin
                if (exp_wr.size() == 0) chk(1'b0, "R4 unexpected write strobe", {21'd0, idx, wdata}, 0);
                else begin
                    e_wr = exp_wr.pop_front();
                    chk({idx, wdata} == e_wr, "R4 write index/data", {21'd0, idx, wdata}, {21'd0, e_wr});
                end
                chk(pull, "R9 ack pull with write strobe", pull, 1);
            end
            if (rd) begin
                if (exp_rd.size() == 0) chk(1'b0, "R5 unexpected read strobe", idx, 0);
                else begin
                    e_rd = exp_rd.pop_front();
                    chk(idx == e_rd, "R5 read strobe index", idx, e_rd);
                end
            end
            if (pull && !pull_q) chk(!m_scl, "R6 pull rises while SCL low", m_scl, 0);
            pull_q <= pull;
        end
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bstart();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = nack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q); m_sda = 1'b1;
    endtask

    task automatic addr_cmd(input logic [6:0] a, input logic [7:0] cmd);
        logic ack;
        bstart();
        send_byte({a, 1'b0}, ack);
        chk(ack == 1'b0, "R2 matching address acknowledged", ack, 0);
        send_byte(cmd, ack);
        chk(ack == 1'b0, "R3 command byte acknowledged", ack, 0);
        m_ptr = cmd[2:0];
    endtask

    task automatic wr_burst(input logic [6:0] a, input logic [7:0] cmd, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] d;
        addr_cmd(a, cmd);
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
            exp_wr.push_back({m_ptr, d});
            model[m_ptr] = d;
            m_ptr = m_ptr ^ 3'd1;
            send_byte(d, ack);
            chk(ack == 1'b0, "R4 data byte acknowledged", ack, 0);
        end
        bstop();
    endtask

    task automatic rd_common(input logic [6:0] a, input int n);
        logic ack;
        logic [7:0] d;
        logic [2:0] p = m_ptr;
        for (int i = 0; i < n; i++) begin
            exp_rd.push_back(p);
            p = p ^ 3'd1;
        end
        bstart();
        send_byte({a, 1'b1}, ack);
        chk(ack == 1'b0, "R2 read address acknowledged", ack, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n-1, d);
            chk(d == model[m_ptr], "R5 read data MSB first", d, model[m_ptr]);
            m_ptr = m_ptr ^ 3'd1;
        end
        wq(2);
        chk(pull == 1'b0, "R5 NACK releases SDA", pull, 0);
        bstop();
    endtask

    initial begin
        logic ack;
        for (int i = 0; i < 8; i++) begin rf[i] = 8'h00; model[i] = 8'h00; end
        wq(5);
        rst = 1'b0;
        wq(3);
        chk(pull == 1'b0 && we == 1'b0 && rd == 1'b0, "R1 reset state", {pull, we, rd}, 0);
        wq(20);
        chk(pull == 1'b0, "R1 idle bus leaves SDA released", pull, 0);

        // R4: burst write alternates within the pair
        wr_burst(7'h25, 8'h02, 3, 8'h11, 8'h22, 8'h33);
        wr_burst(7'h25, 8'h06, 2, 8'hA5, 8'h5A, 8'h00);

        // R5: command then repeated START read
        addr_cmd(7'h25, 8'h06);
        rd_common(7'h25, 3);

        // R2: foreign address, nothing acknowledged, no strobes
        bstart();
        send_byte({7'h26, 1'b0}, ack);
        chk(ack == 1'b1, "R2 foreign address not acknowledged", ack, 1);
        send_byte(8'h03, ack);
        chk(ack == 1'b1, "R2 bytes after foreign address ignored", ack, 1);
        send_byte(8'hEE, ack);
        chk(ack == 1'b1, "R2 bytes after foreign address ignored", ack, 1);
        bstop();

        // R8: pointer kept across transactions, read without command
        rd_common(7'h25, 2);

        // R3: command upper bits ignored
        wr_burst(7'h25, 8'hF8, 1, 8'hC3, 8'h00, 8'h00);

        // R2: strap change moves the address
        strap = 3'b000;
        wq(4);
        bstart();
        send_byte({7'h25, 1'b0}, ack);
        chk(ack == 1'b1, "R2 old strap address rejected", ack, 1);
        bstop();
        wr_burst(7'h20, 8'h01, 1, 8'h7E, 8'h00, 8'h00);

        // R7: START in the middle of an address byte
        bstart();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        wr_burst(7'h20, 8'h04, 2, 8'h99, 8'h66, 8'h00);
        chk(rf[4] == 8'h99 && rf[5] == 8'h66, "R7 transfer after aborted byte", {rf[4], rf[5]}, 16'h9966);

        // R5: longer read alternating 0/1
        addr_cmd(7'h20, 8'h00);
        rd_common(7'h20, 4);

        wq(10);
        chk(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);
        chk(exp_rd.size() == 0, "R5 all expected read strobes seen", exp_rd.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule